// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides whether a received CAN frame header is kept. It compares the header against a bank of programmable acceptance filters. The header consists of the 29-bit identifier, the extended-frame flag and the remote-request flag. The frame is kept when at least one enabled filter agrees with it on every bit that filter's mask selects. For each kept frame the block reports the number of the filter that let it through, and the receive path stores that number next to the frame.

Software programs the bank through a simple write-only register port. One word holds the per-filter enable bits. Each filter also has a compare word and a mask word. The compare word and the mask word share one 31-bit layout, which is the header layout: the remote flag sits in the top bit, the extended flag sits below it, and the identifier fills the rest. Within the identifier, the 11-bit base part is in the upper bits and the 18-bit extension is in the lower bits.

The decision is registered. The accept pulse and the filter number appear one clock after the header strobe. The accept pulse serves directly as the write strobe for the receive FIFO.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every filter is disabled, `accept_o` is low and `match_idx_o` is 0, so no header is accepted until software enables a filter.
- R2: A header key is formed as {rtr, ext, id}, which puts RTR in bit 30, EXT in bit 29 and ID in bits 28-0, with the base ID in bits 28-18. A filter matches only if the key equals its compare word on every bit where its mask word holds 1.
- R3: A key bit whose mask bit is 0 has no effect on whether that filter matches. A filter with an all-zero mask matches every header.
- R4: A filter whose enable bit is 0 never matches, even if its compare word equals the key.
- R5: When several enabled filters match, `match_idx_o` reports the lowest-numbered one.
- R6: A header that matches no enabled filter produces no `accept_o` pulse.
- R7: `accept_o` and `match_idx_o` are valid exactly one clock after the cycle in which `hdr_valid_i` is high, and last one cycle. In every other cycle `accept_o` is 0 and `match_idx_o` is 0.
- R8: The register map is as follows. Address 0 holds the enable bits, with bit k enabling filter k. Address 2+2k is the compare word of filter k, and address 3+2k is its mask word. A write to any other address changes nothing.
- R9: A header presented in the same cycle as a register write is judged with the settings from before that write. The next header sees the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register word address |
| wr_data_i | input | 31 | Register write data |
| hdr_valid_i | input | 1 | Header valid strobe, one cycle per frame |
| hdr_id_i | input | 29 | Received identifier (base ID in 28-18) |
| hdr_ext_i | input | 1 | Received extended-frame flag |
| hdr_rtr_i | input | 1 | Received remote-request flag |
| accept_o | output | 1 | Frame accepted; doubles as FIFO write strobe |
| match_idx_o | output | 5 | Number of the winning filter |

## Verification
The bench first sets up one filter with a full mask. It then flips each of the 31 key bits in turn, which shows that every position, including RTR and EXT, takes part in the compare. It repeats the flips with a mask that selects only the base ID, which separates the compared bits from the ignored ones. A sweep over enable patterns, each with a different lowest enabled filter, shows that lowest-index priority holds and that disabled filters are skipped. Further tests cover writes to unmapped addresses, a header that arrives in the same cycle as a write, and back-to-back headers, which check the one-cycle timing.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int unsigned ID_W    = 29;
  localparam int unsigned KEY_W   = ID_W + 2;
  localparam int unsigned RTR_BIT = KEY_W - 1;
  localparam int unsigned EXT_BIT = KEY_W - 2;

  typedef logic [KEY_W-1:0] key_t;

  function automatic key_t make_key(input logic rtr, input logic ext, input logic [ID_W-1:0] id);
    return {rtr, ext, id};
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 20,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  key_t                wr_data_i,
  output logic [NUM_FILT-1:0] en_o,
  output key_t                val_o  [NUM_FILT],
  output key_t                mask_o [NUM_FILT]
);
  logic [NUM_FILT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            en_q <= '0;
    else if (wr_en_i && wr_addr_i == '0)    en_q <= wr_data_i[NUM_FILT-1:0];
  end
  assign en_o = en_q;

  for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
    localparam logic [ADDR_W-1:0] VAL_ADDR  = ADDR_W'(2 + 2*k);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(3 + 2*k);
    key_t val_q, mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        mask_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == VAL_ADDR)  val_q  <= wr_data_i;
        if (wr_addr_i == MASK_ADDR) mask_q <= wr_data_i;
      end
    end
    assign val_o[k]  = val_q;
    assign mask_o[k] = mask_q;
  end

  // R8: enables move only on a write to address 0
  a_r8_en_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == '0) |=> $stable(en_q));
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 20
) (
  input  key_t                key_i,
  input  logic [NUM_FILT-1:0] en_i,
  input  key_t                val_i  [NUM_FILT],
  input  key_t                mask_i [NUM_FILT],
  output logic [NUM_FILT-1:0] hit_o
);
  for (genvar k = 0; k < NUM_FILT; k++) begin : g_cmp
    assign hit_o[k] = en_i[k] && (((key_i ^ val_i[k]) & mask_i[k]) == '0);
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int unsigned NUM_FILT = 20,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT)
) (
  input  logic [NUM_FILT-1:0] hit_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    idx_o
);
  // scan high to low so the lowest hit is written last
  always_comb begin
    idx_o = '0;
    for (int k = NUM_FILT - 1; k >= 0; k--) begin
      if (hit_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT = 20,
  localparam int unsigned IDX_W   = $clog2(NUM_FILT),
  localparam int unsigned ADDR_W  = $clog2(2*NUM_FILT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_data_i,
  input  logic              hdr_valid_i,
  input  logic [ID_W-1:0]   hdr_id_i,
  input  logic              hdr_ext_i,
  input  logic              hdr_rtr_i,
  output logic              accept_o,
  output logic [IDX_W-1:0]  match_idx_o
);
  logic [NUM_FILT-1:0] en_vec, hit_vec;
  key_t                val_arr  [NUM_FILT];
  key_t                mask_arr [NUM_FILT];
  key_t                key;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;
  logic                accept_q;
  logic [IDX_W-1:0]    idx_q;

  assign key = make_key(hdr_rtr_i, hdr_ext_i, hdr_id_i);

  can_filt_regs #(.NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_vec), .val_o(val_arr), .mask_o(mask_arr)
  );

  can_filt_match #(.NUM_FILT(NUM_FILT)) u_match (
    .key_i(key), .en_i(en_vec), .val_i(val_arr), .mask_i(mask_arr), .hit_o(hit_vec)
  );

  can_filt_prio #(.NUM_FILT(NUM_FILT)) u_prio (
    .hit_i(hit_vec), .any_o(any_hit), .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      accept_q <= hdr_valid_i && any_hit;
      idx_q    <= (hdr_valid_i && any_hit) ? win_idx : '0;
    end
  end

  assign accept_o    = accept_q;
  assign match_idx_o = idx_q;

  a_r7_accept_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_q |-> $past(hdr_valid_i));
  a_r6_no_hit_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hit_vec == '0) |=> !accept_q);
  a_r4_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_q |-> ((($past(en_vec)) >> idx_q) & NUM_FILT'(1)) != '0);
  a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_q |-> ($past(hit_vec) & ((NUM_FILT'(1) << idx_q) - NUM_FILT'(1))) == '0);
  a_r7_idx_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_q |-> idx_q == '0);
endmodule

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  localparam int  NF     = 20;
  localparam int  IW     = $clog2(NF);
  localparam int  AW     = $clog2(2*NF + 2);
  localparam int  KW     = 31;
  localparam time CLK_P  = 10ns;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, hv = 1'b0, ext = 1'b0, rtr = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [KW-1:0] wd = '0;
  logic [28:0]   id = '0;
  logic          acc;
  logic [IW-1:0] idx;

  int errs = 0, checks = 0;
  logic [NF-1:0] m_en;
  logic [KW-1:0] m_val [NF];
  logic [KW-1:0] m_mask [NF];

  always #(CLK_P/2) clk = ~clk;

  can_accept_filter #(.NUM_FILT(NF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wa), .wr_data_i(wd),
    .hdr_valid_i(hv), .hdr_id_i(id), .hdr_ext_i(ext), .hdr_rtr_i(rtr),
    .accept_o(acc), .match_idx_o(idx)
  );

  task automatic chk(input string req, input logic a_act, input logic [IW-1:0] i_act,
                     input logic a_exp, input logic [IW-1:0] i_exp);
    checks++;
    if (a_act !== a_exp || i_act !== i_exp) begin
      errs++;
      $display("FAIL %s: accept=%0b idx=%0d expected accept=%0b idx=%0d",
               req, a_act, i_act, a_exp, i_exp);
    end
  endtask

  // model built from R2-R5
  task automatic model(input logic [KW-1:0] key, output logic a, output logic [IW-1:0] i);
    a = 1'b0; i = '0;
    for (int k = NF - 1; k >= 0; k--)
      if (m_en[k] && (((key ^ m_val[k]) & m_mask[k]) == '0)) begin a = 1'b1; i = IW'(k); end
  endtask

  task automatic wr(input int addr, input logic [KW-1:0] data);
    wr_en = 1'b1; wa = AW'(addr); wd = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr == 0) m_en = data[NF-1:0];
    else if (addr >= 2 && addr < 2*NF + 2) begin
      if (addr % 2 == 0) m_val[(addr-2)/2] = data;
      else               m_mask[(addr-2)/2] = data;
    end
  endtask

  // present header, check result the next cycle and idle the cycle after (R7)
  task automatic send(input string req, input logic [KW-1:0] key);
    logic ea; logic [IW-1:0] ei;
    model(key, ea, ei);
    hv = 1'b1; {rtr, ext, id} = key;
    @(negedge clk);
    hv = 1'b0;
    chk(req, acc, idx, ea, ei);
    @(negedge clk);
    chk("R7 idle", acc, idx, 1'b0, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog: accept=%0b idx=%0d expected completion", acc, idx);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [KW-1:0] base;
    m_en = '0;
    for (int k = 0; k < NF; k++) begin m_val[k] = '0; m_mask[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset", acc, idx, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    send("R1 disabled after reset", '0);

    // R2: full mask, flip each key bit
    base = 31'h5A3C_96E1;
    wr(2, base); wr(3, '1); wr(0, 31'h1);
    send("R2 exact match", base);
    for (int b = 0; b < KW; b++) send("R2 bit flip", base ^ (KW'(1) << b));

    // R3: base ID only (bits 28-18)
    wr(3, 31'h1FFC_0000);
    for (int b = 0; b < KW; b++) send("R3 partial mask flip", base ^ (KW'(1) << b));
    wr(3, '0);
    send("R3 zero mask", 31'h0123_4567);

    // R4: filter 3 matches but disabled, then enabled
    wr(8, 31'h0000_0ABC); wr(9, '1); wr(0, '0);
    send("R4 disabled", 31'h0000_0ABC);
    wr(0, 31'h8);
    send("R4 enabled", 31'h0000_0ABC);
    send("R6 no match", 31'h0000_0ABD);

    // R5: all filters accept anything; sweep lowest enabled
    for (int k = 0; k < NF; k++) wr(3 + 2*k, '0);
    for (int k = 0; k < NF; k++) begin
      wr(0, KW'(((1 << NF) - 1) & ~((1 << k) - 1)));
      send("R5 lowest wins", KW'(k * 12345));
    end
    wr(0, KW'(32'h000A_0000));
    send("R5 sparse enables", '1);

    // R8: unmapped writes change nothing
    wr(0, KW'(1 << 7)); wr(17, '1); wr(16, 31'h0000_0055);
    send("R8 filter 7 match", 31'h0000_0055);
    send("R8 filter 7 miss", 31'h0000_0054);
    wr(1, '1);
    for (int a = 2*NF + 2; a < (1 << AW); a++) wr(a, '1);
    send("R8 unmapped ignored", 31'h0000_0055);
    send("R8 unmapped ignored miss", 31'h0000_0054);

    // R9: header and write in the same cycle
    wr(0, '0);
    begin
      logic ea; logic [IW-1:0] ei;
      model(31'h0000_0055, ea, ei);
      wr_en = 1'b1; wa = '0; wd = KW'(1 << 7);
      hv = 1'b1; {rtr, ext, id} = 31'h0000_0055;
      @(negedge clk);
      wr_en = 1'b0; hv = 1'b0; m_en = NF'(1 << 7);
      chk("R9 old settings", acc, idx, ea, ei);
    end
    send("R9 new settings", 31'h0000_0055);

    // R7: back-to-back headers
    hv = 1'b1; {rtr, ext, id} = 31'h0000_0055;
    @(negedge clk);
    chk("R7 b2b first", acc, idx, 1'b1, IW'(7));
    {rtr, ext, id} = 31'h0000_0056;
    @(negedge clk);
    hv = 1'b0;
    chk("R7 b2b second", acc, idx, 1'b0, '0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule